// File: doc/BRIEF.md
# Sequential Stream Prefetch Buffer

This block sits beside a first-level cache and holds a short run of consecutive cache lines that have not yet been asked for. The buffer keeps them apart from the cache, so lines that are never used do not evict anything from it. The cache presents every lookup to the buffer in the same cycle as its own tag check, together with a flag saying whether its own check missed. A cache miss on the line at the head of the buffer is served from the buffer. Any other cache miss discards the buffer's contents and starts a new stream at the line after the missing one.

The buffer keeps its lines in ascending address order. The line it holds longest is the head. When the head is consumed, the line moves to the cache one cycle later. The head then advances, and exactly one new request goes to the next memory level, for the line after the current tail. Requests leave through a valid/ready port. Fill data returns in request order on a separate port with no back-pressure. A miss on a head line whose fill is still outstanding stalls the cache instead of reporting a miss. Fills that belong to a discarded stream are counted and dropped.

Top module: `stream_prefetch_buf`

## Requirements
- R1: After reset, rq_valid, lk_hit, lk_stall and dl_valid are all 0.
- R2: A lookup with lk_valid=1 and lk_cmiss=1 whose address is not the head line (or that arrives while the buffer is empty) causes requests for exactly the next DEPTH line addresses, addr+1 up to addr+DEPTH, issued in ascending order.
- R3: A lookup with lk_cmiss=0 raises neither lk_hit nor lk_stall and changes neither the head nor the requests.
- R4: A cache miss on the head line whose fill has arrived raises lk_hit in the same cycle. In the next cycle it drives dl_valid=1 with dl_addr equal to the looked-up address.
- R5: Each head hit causes exactly one new request, for the head address plus DEPTH.
- R6: A cache miss on the head line whose fill is still outstanding raises lk_stall and not lk_hit. It starts no new request and leaves the head unchanged until the fill arrives.
- R7: Fills are written in arrival order into the oldest entry still waiting, so each delivered dl_data is the data returned for dl_addr.
- R8: Fills for requests issued before a flush are discarded and never delivered for lines of the new stream.
- R9: While rq_valid=1 and rq_ready=0, with no cache-miss lookup in that cycle, rq_valid stays 1 and rq_addr is unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup presented this cycle |
| lk_cmiss | input | 1 | The cache's own lookup missed |
| lk_addr | input | LAW | Line address of the lookup |
| lk_hit | output | 1 | Head line present, served next cycle |
| lk_stall | output | 1 | Head line requested but its fill is outstanding |
| dl_valid | output | 1 | Line delivered to the cache |
| dl_addr | output | LAW | Address of the delivered line |
| dl_data | output | DW | Data of the delivered line |
| rq_valid | output | 1 | Line request to the next level |
| rq_ready | input | 1 | Next level accepts the request |
| rq_addr | output | LAW | Requested line address |
| fl_valid | input | 1 | Fill returned, in request order |
| fl_data | input | DW | Fill data |

## Verification
The assertions check on every cycle that hit and stall never coincide and that lookups without a cache miss stay silent. They also check that every hit produces a delivery of the looked-up address one cycle later, that no delivery appears without a hit, and that a refused request holds its address. Only the bench scenarios can show the request sequences and their number, the data pairing of in-order fills, and the discarding of fills from a flushed stream. The bench computes these against an arithmetic data pattern, with the memory latency and ready patterns varied.

// File: rtl/stream_prefetch_buf.sv
module stream_prefetch_buf #(
  parameter int DEPTH = 4,
  parameter int LAW   = 26,
  parameter int DW    = 64
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           lk_valid,
  input  logic           lk_cmiss,
  input  logic [LAW-1:0] lk_addr,
  output logic           lk_hit,
  output logic           lk_stall,
  output logic           dl_valid,
  output logic [LAW-1:0] dl_addr,
  output logic [DW-1:0]  dl_data,
  output logic           rq_valid,
  input  logic           rq_ready,
  output logic [LAW-1:0] rq_addr,
  input  logic           fl_valid,
  input  logic [DW-1:0]  fl_data
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int SW = CW + 4;

  logic           act;
  logic [LAW-1:0] head_a;
  logic [PW-1:0]  rd_p;
  logic [CW-1:0]  n_iss, n_fill;
  logic [SW-1:0]  stale;
  logic [DW-1:0]  mem [DEPTH];

  logic lk_go, head_m, flush, rq_fire, f_stale, f_live;
  logic [PW-1:0] wr_p;

  assign lk_go    = lk_valid & lk_cmiss;
  assign head_m   = act & (lk_addr == head_a);
  assign lk_hit   = lk_go & head_m & (n_fill != '0);
  assign lk_stall = lk_go & head_m & (n_fill == '0);
  assign flush    = lk_go & ~head_m;

  assign rq_valid = act & (n_iss < CW'(DEPTH));
  assign rq_addr  = head_a + LAW'(n_iss);
  assign rq_fire  = rq_valid & rq_ready;

  assign f_stale  = fl_valid & (stale != '0);
  assign f_live   = fl_valid & (stale == '0);
  assign wr_p     = rd_p + PW'(n_fill);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act    <= 1'b0;
      head_a <= '0;
      rd_p   <= '0;
      n_iss  <= '0;
      n_fill <= '0;
      stale  <= '0;
    end else if (flush) begin
      act    <= 1'b1;
      head_a <= lk_addr + LAW'(1);
      rd_p   <= '0;
      n_iss  <= '0;
      n_fill <= '0;
      stale  <= stale - SW'(f_stale) + SW'(n_iss) - SW'(n_fill)
                - SW'(f_live) + SW'(rq_fire);
    end else begin
      stale  <= stale - SW'(f_stale);
      n_iss  <= n_iss + CW'(rq_fire) - CW'(lk_hit);
      n_fill <= n_fill + CW'(f_live) - CW'(lk_hit);
      if (lk_hit) begin
        head_a <= head_a + LAW'(1);
        rd_p   <= rd_p + PW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (f_live && !flush)
      mem[wr_p] <= fl_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dl_valid <= 1'b0;
      dl_addr  <= '0;
      dl_data  <= '0;
    end else begin
      dl_valid <= lk_hit;
      if (lk_hit) begin
        dl_addr <= head_a;
        dl_data <= mem[rd_p];
      end
    end
  end
endmodule

// File: rtl/stream_prefetch_buf_chk.sv
module stream_prefetch_buf_chk #(
  parameter int LAW = 26
) (
  input logic           clk,
  input logic           rst_n,
  input logic           lk_valid,
  input logic           lk_cmiss,
  input logic [LAW-1:0] lk_addr,
  input logic           lk_hit,
  input logic           lk_stall,
  input logic           dl_valid,
  input logic [LAW-1:0] dl_addr,
  input logic           rq_valid,
  input logic           rq_ready,
  input logic [LAW-1:0] rq_addr
);
  // R6
  hit_stall_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_hit && lk_stall));

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_valid && lk_cmiss) |-> !lk_hit && !lk_stall);

  // R4
  deliver_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |=> dl_valid && dl_addr == $past(lk_addr));

  // R4
  deliver_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dl_valid |-> $past(lk_hit));

  // R6
  stall_nodl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_stall |=> !dl_valid);

  // R9
  rq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid && !rq_ready && !(lk_valid && lk_cmiss) |=> rq_valid && $stable(rq_addr));
endmodule

bind stream_prefetch_buf stream_prefetch_buf_chk #(.LAW(LAW)) u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_cmiss(lk_cmiss),
  .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_stall(lk_stall),
  .dl_valid(dl_valid), .dl_addr(dl_addr), .rq_valid(rq_valid),
  .rq_ready(rq_ready), .rq_addr(rq_addr)
);

// File: tb/test_stream_prefetch_buf.sv
module test_stream_prefetch_buf;
  localparam int CLK_T = 10;
  localparam int D  = 4;
  localparam int AW = 26;
  localparam int W  = 64;

  logic clk = 0, rst_n = 0;
  logic lk_valid = 0, lk_cmiss = 0, rq_ready, fl_valid;
  logic [AW-1:0] lk_addr = '0;
  logic [W-1:0]  fl_data;
  logic lk_hit, lk_stall, dl_valid, rq_valid;
  logic [AW-1:0] dl_addr, rq_addr;
  logic [W-1:0]  dl_data;

  int checks = 0, errors = 0, cyc = 0;
  int lat = 3, rdy_mode = 0, resp_en = 1;
  logic [AW-1:0] q_a [256];
  int q_t [256];
  int qh, qt, nlog;
  logic [AW-1:0] rlog [256];

  stream_prefetch_buf #(.DEPTH(D), .LAW(AW), .DW(W)) i_stream_prefetch_buf (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_cmiss(lk_cmiss),
    .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_stall(lk_stall),
    .dl_valid(dl_valid), .dl_addr(dl_addr), .dl_data(dl_data),
    .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_addr(rq_addr),
    .fl_valid(fl_valid), .fl_data(fl_data));

  always #(CLK_T/2) clk = ~clk;
  initial forever begin @(posedge clk); cyc++; end

  function automatic logic [W-1:0] fd(logic [AW-1:0] a);
    return {6'd0, a, 32'h5A5A0000 ^ {6'd0, a}};
  endfunction

  initial begin
    fl_valid = 0; fl_data = '0; rq_ready = 0; qh = 0; qt = 0; nlog = 0;
    forever begin
      @(negedge clk);
      fl_valid = 0;
      rq_ready = rst_n && (rdy_mode == 0 || cyc[0]);
      if (rq_valid && rq_ready) begin
        q_a[qt % 256] = rq_addr; q_t[qt % 256] = cyc + lat; qt++;
        rlog[nlog % 256] = rq_addr; nlog++;
      end
      if (resp_en != 0 && qh != qt && q_t[qh % 256] <= cyc) begin
        fl_valid = 1; fl_data = fd(q_a[qh % 256]); qh++;
      end
    end
  end

  task automatic chk(bit ok, string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_miss(logic [AW-1:0] a);
    lk_valid = 1; lk_cmiss = 1; lk_addr = a;
    #1 chk(!lk_hit && !lk_stall, "R2 flushing miss not a hit", W'(lk_hit), 0);
    @(negedge clk); lk_valid = 0; lk_cmiss = 0;
  endtask

  task automatic do_hit(logic [AW-1:0] a);
    int k = 0;
    lk_valid = 1; lk_cmiss = 1; lk_addr = a;
    #1;
    while (lk_stall && k < 300) begin @(negedge clk); #1; k++; end
    chk(lk_hit == 1, "R4 head hit", W'(lk_hit), 1);
    @(negedge clk); lk_valid = 0; lk_cmiss = 0;
    #1;
    chk(dl_valid == 1 && dl_addr == a, "R4 delivery", W'(dl_addr), W'(a));
    chk(dl_data == fd(a), "R7 R8 delivered data", dl_data, fd(a));
  endtask

  task automatic expect_reqs(logic [AW-1:0] start, int n, string tag);
    int k = -1, t = 0;
    while (k < 0 && t < 200) begin
      for (int i = (nlog > 24 ? nlog - 24 : 0); i < nlog; i++)
        if (rlog[i % 256] == start) k = i;
      if (k < 0) begin @(negedge clk); t++; end
    end
    chk(k >= 0, tag, 0, W'(start));
    if (k >= 0) begin
      t = 0;
      while (nlog < k + n && t < 200) begin @(negedge clk); t++; end
      for (int i = 0; i < n; i++)
        chk(rlog[(k + i) % 256] == start + AW'(i), tag,
            W'(rlog[(k + i) % 256]), W'(start + AW'(i)));
      repeat (10) @(negedge clk);
      chk(nlog == k + n, {tag, " no extra request"}, W'(nlog - k), W'(n));
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!rq_valid && !lk_hit && !lk_stall && !dl_valid, "R1 reset outputs",
        W'({rq_valid, lk_hit, lk_stall, dl_valid}), 0);
    rst_n = 1;
    @(negedge clk);
    chk(!rq_valid && !dl_valid, "R1 idle after reset", W'({rq_valid, dl_valid}), 0);

    // R2 first stream
    do_miss(AW'(100));
    expect_reqs(AW'(101), D, "R2 stream start");

    // R4 R5 R7 sweep of head hits, always ready
    for (int x = 101; x < 111; x++) begin
      do_hit(AW'(x));
      expect_reqs(AW'(x + D), 1, "R5 one refill");
    end

    // R3 lookups without a cache miss are ignored
    lk_valid = 1; lk_cmiss = 0; lk_addr = AW'(111);
    #1 chk(!lk_hit && !lk_stall, "R3 no hit on cache hit", W'({lk_hit, lk_stall}), 0);
    @(negedge clk); lk_addr = AW'(7777);
    #1 chk(!lk_hit && !lk_stall, "R3 no flush on cache hit", W'({lk_hit, lk_stall}), 0);
    @(negedge clk); lk_valid = 0;
    #1 chk(!dl_valid, "R3 no delivery", W'(dl_valid), 0);
    do_hit(AW'(111));
    expect_reqs(AW'(111 + D), 1, "R3 R5 head unchanged");

    // R9 R5 R7 toggling ready, longer latency
    rdy_mode = 1; lat = 6;
    do_miss(AW'(3000));
    expect_reqs(AW'(3001), D, "R2 R9 stream under back-pressure");
    for (int x = 3001; x < 3009; x++) begin
      do_hit(AW'(x));
      expect_reqs(AW'(x + D), 1, "R5 R9 refill");
    end
    rdy_mode = 0;

    // R6 stall on pending head
    resp_en = 0; lat = 2;
    do_miss(AW'(500));
    expect_reqs(AW'(501), D, "R2 stream for stall");
    lk_valid = 1; lk_cmiss = 1; lk_addr = AW'(501);
    for (int i = 0; i < 5; i++) begin
      #1 chk(lk_stall && !lk_hit, "R6 stall while pending", W'({lk_stall, lk_hit}), 2);
      @(negedge clk);
      chk(!dl_valid, "R6 no delivery in stall", W'(dl_valid), 0);
    end
    chk(rlog[(nlog - 1) % 256] == AW'(504), "R6 no request in stall",
        W'(rlog[(nlog - 1) % 256]), 504);
    resp_en = 1;
    do_hit(AW'(501));
    expect_reqs(AW'(501 + D), 1, "R6 R5 refill after stall");

    // R8 flush with fills in flight
    lat = 12;
    do_miss(AW'(900));
    repeat (2) @(negedge clk);
    do_miss(AW'(2000));
    expect_reqs(AW'(2001), D, "R2 R8 restart");
    for (int x = 2001; x < 2005; x++) do_hit(AW'(x));

    // R2 back-to-back flush with idle buffer beyond
    lat = 1;
    do_miss(AW'(40));
    expect_reqs(AW'(41), D, "R2 short latency");
    do_hit(AW'(41));

    repeat (5) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule